// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch RAM

This block is the 128-byte internal data store of a small 8-bit controller core. A single byte port reaches every location, with either a direct or an indirect address. A register port reaches the eight working registers of the current bank. A bit port sets, clears, writes or reads any one of 128 flags without touching the bits around it. All three ports share one storage array and may act on it in the same clock.

The low 32 bytes hold four banks of eight working registers. A small bank register selects which bank the register port sees. It comes out of reset on bank 0 and changes only on an explicit load. Sixteen bytes starting at 20H double as the flag area. Bytes 30H and above are plain scratch storage. All reads are registered. Out-of-range addresses are harmless: they do nothing on write and read as zero.

Top module: `banked_bit_ram`

## Requirements
- R1: Byte addresses 00H to 7FH can all be written through the byte port and read back. Read data appears one cycle after the address is presented. After reset every byte reads as 00H.
- R2: A read in the same cycle as a write to the same byte, or to the same bit, returns the value held before that write.
- R3: Register index n of bank b refers to the byte at address b*8 + n. The register port and the byte port see the same storage.
- R4: The active bank is 0 after reset. Asserting `bank_load_i` copies `bank_sel_i` into the bank register at the clock edge. A register access made in that same cycle still uses the previous bank.
- R5: Bit address k refers to bit (k mod 8) of byte 20H + (k div 8). The `bit_op_i` codes are: 00 none, 01 set, 10 clear, 11 write `bit_wdata_i`. `bit_rdata_o` shows the addressed bit one cycle later.
- R6: A bit operation changes only the addressed bit and takes effect in one clock.
- R7: When several ports write the same byte in one cycle, the byte-port data is applied first. Register-port data then replaces it. The bit operation is applied last, on top of the result.
- R8: A byte address of 80H or above, or a bit address of 80H or above, changes no storage and reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_we_i | input | 1 | Byte-port write enable |
| byte_addr_i | input | 8 | Byte address, direct or indirect |
| byte_wdata_i | input | 8 | Byte-port write data |
| byte_rdata_o | output | 8 | Registered byte read data |
| bank_load_i | input | 1 | Load the bank register |
| bank_sel_i | input | 2 | New bank value |
| reg_we_i | input | 1 | Register-port write enable |
| reg_idx_i | input | 3 | Working register index |
| reg_wdata_i | input | 8 | Register-port write data |
| reg_rdata_o | output | 8 | Registered register read data |
| bit_op_i | input | 2 | Bit operation code |
| bit_addr_i | input | 8 | Bit address |
| bit_wdata_i | input | 1 | Value for a bit write |
| bit_rdata_o | output | 1 | Registered bit read data |

## Verification
The assertions expect the bit address to stay constant between a set or clear and the read that follows it when they check the result. They also expect a bank load to be a single-cycle pulse whose value is sampled at the edge. Reads are treated as continuous, so the byte and register taps are compared only when the byte address equals the register location in the active bank. The stimulus changes inputs only at falling edges and holds every operation code at "none" when idle. This means no stray bit operation or register write can land between a write and the read that checks it.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    BIT_NOP = 2'b00,
    BIT_SET = 2'b01,
    BIT_CLR = 2'b10,
    BIT_WR  = 2'b11
  } bit_op_e;
endpackage

// File: rtl/bbr_bank_reg.sv
module bbr_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] sel_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (load_i) bank_o <= sel_i;
  end
endmodule

// File: rtl/bbr_addr_map.sv
module bbr_addr_map #(
  parameter int DEPTH     = 128,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 7,
  parameter int BANK_W    = 2,
  parameter int REG_W     = 3,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16
) (
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              byte_ok_o,
  output logic [IDX_W-1:0]  reg_loc_o,
  output logic [IDX_W-1:0]  bit_byte_o,
  output logic [2:0]        bit_pos_o,
  output logic              bit_ok_o
);
  localparam int BIT_COUNT = BIT_BYTES * 8;

  assign byte_ok_o  = 32'(byte_addr_i) < DEPTH;
  assign byte_idx_o = byte_addr_i[IDX_W-1:0];
  // banks sit at the bottom of the array
  assign reg_loc_o  = IDX_W'({bank_i, reg_idx_i});
  assign bit_ok_o   = 32'(bit_addr_i) < BIT_COUNT;
  assign bit_byte_o = IDX_W'(BIT_BASE) + IDX_W'(bit_addr_i[ADDR_W-1:3]);
  assign bit_pos_o  = bit_addr_i[2:0];
endmodule

// File: rtl/bbr_store.sv
module bbr_store
  import bbr_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int IDX_W     = 7,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_we_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  logic [7:0]       byte_wdata_i,
  input  logic             reg_we_i,
  input  logic [IDX_W-1:0] reg_loc_i,
  input  logic [7:0]       reg_wdata_i,
  input  bit_op_e          bit_op_i,
  input  logic [IDX_W-1:0] bit_byte_i,
  input  logic [2:0]       bit_pos_i,
  input  logic             bit_wdata_i,
  output logic [7:0]       byte_tap_o,
  output logic [7:0]       reg_tap_o,
  output logic             bit_tap_o
);
  logic [DEPTH*8-1:0] mem_flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [7:0] q;
    logic [7:0] nxt;

    if (i >= BIT_BASE && i < BIT_BASE + BIT_BYTES) begin : g_bitcell
      always_comb begin
        nxt = q;
        if (byte_we_i && byte_idx_i == IDX_W'(i)) nxt = byte_wdata_i;
        if (reg_we_i && reg_loc_i == IDX_W'(i))   nxt = reg_wdata_i;
        if (bit_byte_i == IDX_W'(i)) begin
          unique case (bit_op_i)
            BIT_SET: nxt[bit_pos_i] = 1'b1;
            BIT_CLR: nxt[bit_pos_i] = 1'b0;
            BIT_WR:  nxt[bit_pos_i] = bit_wdata_i;
            default: ;
          endcase
        end
      end
    end else begin : g_plain
      always_comb begin
        nxt = q;
        if (byte_we_i && byte_idx_i == IDX_W'(i)) nxt = byte_wdata_i;
        if (reg_we_i && reg_loc_i == IDX_W'(i))   nxt = reg_wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end

    assign mem_flat[i*8 +: 8] = q;
  end

  assign byte_tap_o = mem_flat[byte_idx_i*8 +: 8];
  assign reg_tap_o  = mem_flat[reg_loc_i*8 +: 8];
  assign bit_tap_o  = mem_flat[{bit_byte_i, bit_pos_i}];
endmodule

// File: rtl/banked_bit_ram.sv
module banked_bit_ram
  import bbr_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int BANKS     = 4,
  parameter int REGS      = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int ADDR_W   = IDX_W + 1,
  localparam int BANK_W   = $clog2(BANKS),
  localparam int REG_W    = $clog2(REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [7:0]        byte_wdata_i,
  output logic [7:0]        byte_rdata_o,
  input  logic              bank_load_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_idx_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [1:0]        bit_op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic              bit_wdata_i,
  output logic              bit_rdata_o
);
  logic [BANK_W-1:0] bank_cur;
  logic [IDX_W-1:0]  byte_idx, reg_loc, bit_byte;
  logic [2:0]        bit_pos;
  logic              byte_ok, bit_ok;
  logic [7:0]        byte_tap, reg_tap;
  logic              bit_tap;
  bit_op_e           bit_op_q;

  bbr_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bank_load_i),
    .sel_i  (bank_sel_i),
    .bank_o (bank_cur)
  );

  bbr_addr_map #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W),
    .REG_W(REG_W), .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
  ) u_map (
    .byte_addr_i (byte_addr_i),
    .bank_i      (bank_cur),
    .reg_idx_i   (reg_idx_i),
    .bit_addr_i  (bit_addr_i),
    .byte_idx_o  (byte_idx),
    .byte_ok_o   (byte_ok),
    .reg_loc_o   (reg_loc),
    .bit_byte_o  (bit_byte),
    .bit_pos_o   (bit_pos),
    .bit_ok_o    (bit_ok)
  );

  // invalid bit addresses degrade to no operation
  assign bit_op_q = bit_ok ? bit_op_e'(bit_op_i) : BIT_NOP;

  bbr_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_we_i    (byte_we_i && byte_ok),
    .byte_idx_i   (byte_idx),
    .byte_wdata_i (byte_wdata_i),
    .reg_we_i     (reg_we_i),
    .reg_loc_i    (reg_loc),
    .reg_wdata_i  (reg_wdata_i),
    .bit_op_i     (bit_op_q),
    .bit_byte_i   (bit_byte),
    .bit_pos_i    (bit_pos),
    .bit_wdata_i  (bit_wdata_i),
    .byte_tap_o   (byte_tap),
    .reg_tap_o    (reg_tap),
    .bit_tap_o    (bit_tap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_rdata_o <= '0;
      reg_rdata_o  <= '0;
      bit_rdata_o  <= 1'b0;
    end else begin
      byte_rdata_o <= byte_ok ? byte_tap : 8'h00;
      reg_rdata_o  <= reg_tap;
      bit_rdata_o  <= bit_ok && bit_tap;
    end
  end
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] byte_addr_i,
  input logic [7:0]        byte_rdata_o,
  input logic              bank_load_i,
  input logic [BANK_W-1:0] bank_sel_i,
  input logic [REG_W-1:0]  reg_idx_i,
  input logic [7:0]        reg_rdata_o,
  input logic [1:0]        bit_op_i,
  input logic [ADDR_W-1:0] bit_addr_i,
  input logic              bit_rdata_o,
  input logic [BANK_W-1:0] bank_cur
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(128);

  assert_oor_byte_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_addr_i >= LIMIT) |-> byte_rdata_o == 8'h00);

  assert_oor_bit_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bit_addr_i >= LIMIT) |-> !bit_rdata_o);

  assert_reg_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byte_addr_i == ADDR_W'({bank_cur, reg_idx_i})) |-> reg_rdata_o == byte_rdata_o);

  assert_bank_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bank_load_i) |-> bank_cur == $past(bank_sel_i));

  assert_bit_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'b01 && bit_addr_i < LIMIT) ##1 (bit_addr_i == $past(bit_addr_i))
    |=> bit_rdata_o);

  assert_bit_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'b10 && bit_addr_i < LIMIT) ##1 (bit_addr_i == $past(bit_addr_i))
    |=> !bit_rdata_o);
endmodule

bind banked_bit_ram bbr_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_addr_i  (byte_addr_i),
  .byte_rdata_o (byte_rdata_o),
  .bank_load_i  (bank_load_i),
  .bank_sel_i   (bank_sel_i),
  .reg_idx_i    (reg_idx_i),
  .reg_rdata_o  (reg_rdata_o),
  .bit_op_i     (bit_op_i),
  .bit_addr_i   (bit_addr_i),
  .bit_rdata_o  (bit_rdata_o),
  .bank_cur     (bank_cur)
);

// File: tb/banked_bit_ram_bench.sv
`timescale 1ns/1ps
module banked_bit_ram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_we = 1'b0;
  logic [7:0] byte_addr = '0, byte_wdata = '0, byte_rdata;
  logic       bank_load = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [1:0] bit_op = 2'b00;
  logic [7:0] bit_addr = '0;
  logic       bit_wdata = 1'b0, bit_rdata;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_bit_ram u_banked_bit_ram (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_we_i(byte_we), .byte_addr_i(byte_addr), .byte_wdata_i(byte_wdata),
    .byte_rdata_o(byte_rdata),
    .bank_load_i(bank_load), .bank_sel_i(bank_sel),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .bit_op_i(bit_op), .bit_addr_i(bit_addr), .bit_wdata_i(bit_wdata),
    .bit_rdata_o(bit_rdata)
  );

  // kinds: 0 byte write, 1 byte read, 2 bit set, 3 bit clear, 4 bit write, 5 bit read
  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 8'h30, 8'hA5, 8'h00, 4'd1},  // R1
    '{3'd1, 8'h30, 8'h00, 8'hA5, 4'd1},  // R1
    '{3'd0, 8'h7F, 8'h3C, 8'h00, 4'd1},  // R1 top byte
    '{3'd1, 8'h7F, 8'h00, 8'h3C, 4'd1},  // R1
    '{3'd0, 8'h80, 8'hFF, 8'h00, 4'd8},  // R8 ignored write
    '{3'd1, 8'h80, 8'h00, 8'h00, 4'd8},  // R8 reads zero
    '{3'd1, 8'h00, 8'h00, 8'h00, 4'd8},  // R8 no wrap to 00
    '{3'd2, 8'h03, 8'h00, 8'h00, 4'd5},  // R5 set byte 20 bit 3
    '{3'd1, 8'h20, 8'h00, 8'h08, 4'd5},  // R5
    '{3'd2, 8'h7F, 8'h00, 8'h00, 4'd5},  // R5 last flag
    '{3'd1, 8'h2F, 8'h00, 8'h80, 4'd5},  // R5
    '{3'd0, 8'h25, 8'hFF, 8'h00, 4'd6},  // R6
    '{3'd3, 8'h2A, 8'h00, 8'h00, 4'd6},  // R6 clear byte 25 bit 2
    '{3'd1, 8'h25, 8'h00, 8'hFB, 4'd6},  // R6 neighbours kept
    '{3'd4, 8'h29, 8'h00, 8'h00, 4'd6},  // R6 write 0 to byte 25 bit 1
    '{3'd5, 8'h29, 8'h00, 8'h00, 4'd5},  // R5 bit read
    '{3'd5, 8'h28, 8'h00, 8'h01, 4'd6},  // R6 neighbour bit
    '{3'd1, 8'h25, 8'h00, 8'hF9, 4'd6},  // R6
    '{3'd2, 8'h85, 8'h00, 8'h00, 4'd8},  // R8 ignored bit set
    '{3'd1, 8'h20, 8'h00, 8'h08, 4'd8},  // R8 byte 20 untouched
    '{3'd5, 8'h85, 8'h00, 8'h00, 4'd8},  // R8 bit reads zero
    '{3'd4, 8'h10, 8'h01, 8'h00, 4'd5},  // R5 write 1 to byte 22 bit 0
    '{3'd1, 8'h22, 8'h00, 8'h01, 4'd5}   // R5
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    byte_we = 1'b0; reg_we = 1'b0; bank_load = 1'b0; bit_op = 2'b00;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
    byte_we = 1'b1; byte_addr = a; byte_wdata = d;
    tick();
    idle();
  endtask

  task automatic byte_rd_check(input string tag, input logic [7:0] a, input logic [7:0] e);
    byte_addr = a;
    tick();
    check(tag, byte_rdata, e);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    // R1 reset state of all read outputs
    check("R1 reset byte", byte_rdata, 8'h00);
    check("R1 reset reg", reg_rdata, 8'h00);
    check("R1 reset bit", {7'b0, bit_rdata}, 8'h00);
    rst_n = 1'b1;
    tick();
    byte_rd_check("R1 reset content", 8'h45, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      case (v.kind)
        3'd0: byte_wr(v.addr, v.data);
        3'd1: byte_rd_check(tag, v.addr, v.exp);
        3'd2, 3'd3, 3'd4: begin
          bit_op = (v.kind == 3'd2) ? 2'b01 : (v.kind == 3'd3) ? 2'b10 : 2'b11;
          bit_addr = v.addr; bit_wdata = v.data[0];
          tick();
          idle();
        end
        default: begin
          bit_addr = v.addr;
          tick();
          check(tag, {7'b0, bit_rdata}, v.exp);
        end
      endcase
    end

    // R3 bank 0 register 5 is byte 05
    reg_we = 1'b1; reg_idx = 3'd5; reg_wdata = 8'h5A;
    tick(); idle();
    byte_rd_check("R3 bank0 r5", 8'h05, 8'h5A);

    // R4 load bank 2 while writing: write still goes to bank 0
    bank_load = 1'b1; bank_sel = 2'd2;
    reg_we = 1'b1; reg_idx = 3'd3; reg_wdata = 8'h77;
    tick(); idle();
    reg_we = 1'b1; reg_idx = 3'd3; reg_wdata = 8'h99;
    tick(); idle();
    byte_rd_check("R4 old bank used", 8'h03, 8'h77);
    byte_rd_check("R3 bank2 r3 at 13", 8'h13, 8'h99);
    reg_idx = 3'd3;
    tick();
    check("R3 reg read bank2", reg_rdata, 8'h99);

    byte_wr(8'h1D, 8'hC3);
    bank_load = 1'b1; bank_sel = 2'd3;
    tick(); idle();
    reg_idx = 3'd5;
    tick();
    check("R3 bank3 r5 at 1D", reg_rdata, 8'hC3);

    // R2 read during write returns old data
    byte_wr(8'h31, 8'h11);
    byte_we = 1'b1; byte_addr = 8'h31; byte_wdata = 8'h22;
    tick(); idle();
    check("R2 byte old value", byte_rdata, 8'h11);
    byte_rd_check("R2 byte new value", 8'h31, 8'h22);
    bit_op = 2'b01; bit_addr = 8'h40;
    tick(); idle();
    check("R2 bit old value", {7'b0, bit_rdata}, 8'h00);
    tick();
    check("R2 bit new value", {7'b0, bit_rdata}, 8'h01);

    // R7 byte write then bit op on top
    byte_we = 1'b1; byte_addr = 8'h22; byte_wdata = 8'h0F;
    bit_op = 2'b01; bit_addr = 8'h17;
    tick(); idle();
    byte_rd_check("R7 byte plus bit", 8'h22, 8'h8F);
    // R7 register write overrides byte write (bank 3, r6 = 1E)
    byte_we = 1'b1; byte_addr = 8'h1E; byte_wdata = 8'hAA;
    reg_we = 1'b1; reg_idx = 3'd6; reg_wdata = 8'h55;
    tick(); idle();
    byte_rd_check("R7 reg over byte", 8'h1E, 8'h55);
    // R7 all three on one flag byte (bank 3 r0 is 18, not a flag byte: use byte port + bit)
    byte_we = 1'b1; byte_addr = 8'h2C; byte_wdata = 8'hFF;
    bit_op = 2'b10; bit_addr = 8'h60;
    tick(); idle();
    byte_rd_check("R7 clear on top", 8'h2C, 8'hFE);

    // R4 reset returns bank to 0, R1 reset clears content
    do_reset();
    reg_we = 1'b1; reg_idx = 3'd2; reg_wdata = 8'h44;
    tick(); idle();
    byte_rd_check("R4 bank0 after reset", 8'h02, 8'h44);
    byte_rd_check("R1 cleared by reset", 8'h30, 8'h00);

    done = 1'b1;
    report();
  end
endmodule